// File: doc/BRIEF.md
# Keccak Step Execution Unit

This unit holds a Keccak-f permutation state of 25 lanes and applies one step mapping to the whole state per command. The steps are theta, rho combined with pi, chi, and iota. Software builds a round by issuing four step commands in sequence, and a full permutation by repeating that round. The command arrives as a 32-bit R-type instruction word in the custom-0 opcode space. A fifth command value reloads the round-constant generator that feeds iota. Each iota command consumes one round constant and advances the generator.

A lane port lets a neighbouring load/store path write any lane by index and read any lane combinationally, so the state can be loaded before a permutation and unloaded after it. The lane width is a parameter. At 64 bits the unit holds the 1600-bit state. The narrower power-of-two widths give the smaller permutation sizes, with the rotation amounts reduced modulo the width and the round constants truncated to the width.

Top module: `keccak_step_unit`

## Requirements
- R1: After synchronous reset every lane reads zero, `busy` and `done` are low and `cmd_ready` is high. The round-constant generator holds the value 0x01.
- R2: While idle, `lane_we` with `lane_idx` below 25 writes `lane_wdata` into that lane on the clock edge. `lane_rdata` shows the lane at `lane_idx` in the same cycle. Lane (x,y) sits at index x+5y. An index of 25 or more is a write with no effect and reads as zero.
- R3: A word is a legal command only if bits [6:0] equal 0001011, bits [31:15] and [11:7] are all zero, and bits [14:12] are one of 000 theta, 001 rho-pi, 010 chi, 011 iota, 100 generator reload. Any other word is taken from the port but raises neither `busy` nor `done` and leaves the state as it was.
- R4: A legal command is taken on an edge where `cmd_valid` and `cmd_ready` are both high. `busy` is high for exactly the next cycle, with `cmd_ready` low during that cycle. In the cycle after that, `done` is high for one cycle and the lanes already hold the result. A command held on the port while the unit is busy is taken after the unit is done.
- R5: Theta forms the parity of each column x over its five lanes. It then XORs the parity of column x-1, XORed with the parity of column x+1 rotated left by one, into every lane of column x (indices modulo 5).
- R6: Rho-pi leaves lane (0,0) unchanged. It walks 24 steps t=0..23 from (1,0), each step moving (x,y) to (y,(2x+3y) mod 5). At each step it writes the lane from the previous position into the new position, rotated left by ((t+1)(t+2)/2) modulo the lane width.
- R7: Chi sets each lane of a row to a[x] XOR (NOT a[x+1] AND a[x+2]), indices modulo 5, with all inputs taken from the row before the step.
- R8: Iota XORs a round constant into lane 0 only. The generator is an 8-bit register that is stepped seven times per constant. Step j outputs bit 0 of the register and then shifts it left by one, XORing in 0x71 when bit 7 was set. A 1 at step j sets constant bit 2^j-1. The register keeps its advanced value for the next iota.
- R9: The reload command (funct3 100) puts 0x01 back into the generator, so the next iota uses the first round constant again. The lanes are left unchanged.
- R10: While `busy` is high, `lane_rdata` reads zero and a lane write has no effect.
- R11: On an all-zero 64-bit-lane state, a reload followed by 24 rounds of theta, rho-pi, chi and iota leaves lane 0 at 0xF1258F7940E1DDE7 and lane 1 at 0x84D5CCF933C0478A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command word present |
| cmd_insn | input | 32 | Instruction word to decode |
| cmd_ready | output | 1 | Unit can take a command |
| busy | output | 1 | A step is being applied |
| done | output | 1 | One-cycle pulse; state updated |
| lane_we | input | 1 | Lane write strobe |
| lane_idx | input | 5 | Lane index x+5y |
| lane_wdata | input | LANE_W | Lane write data |
| lane_rdata | output | LANE_W | Lane read data |

## Verification
The bench builds the unit with its default 64-bit lane width, which is the only width where a published known answer exists. That answer is the output of the full permutation on a zero state, and it checks every step and all 24 round constants at once. At this width the seventh constant bit lands in bit 63, the top lane bit, so a misplaced or truncated constant shows up. Rotation amounts above 32 also occur only at this width, so they are exercised without the modulo reduction that narrower widths apply.

// File: rtl/ksu_pkg.sv
`timescale 1ns/1ps
package ksu_pkg;
   localparam int NUM_LANES = 25;
   localparam int IDX_W     = 5;
   localparam logic [6:0] CMD_OPCODE = 7'b0001011;

   typedef enum logic [2:0] {
      OP_THETA = 3'd0,
      OP_RHOPI = 3'd1,
      OP_CHI   = 3'd2,
      OP_IOTA  = 3'd3,
      OP_RCRST = 3'd4
   } step_op_e;
endpackage

// File: rtl/ksu_decode.sv
`timescale 1ns/1ps
module ksu_decode
   import ksu_pkg::*;
(
   input  logic [31:0] insn,
   output logic        legal,
   output step_op_e    op
);
   logic fields_zero;
   assign fields_zero = (insn[31:15] == '0) && (insn[11:7] == '0);

   always_comb begin
      op    = OP_THETA;
      legal = (insn[6:0] == CMD_OPCODE) && fields_zero;
      case (insn[14:12])
         3'd0:    op = OP_THETA;
         3'd1:    op = OP_RHOPI;
         3'd2:    op = OP_CHI;
         3'd3:    op = OP_IOTA;
         3'd4:    op = OP_RCRST;
         default: legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/ksu_rc_gen.sv
`timescale 1ns/1ps
module ksu_rc_gen #(
   parameter int LANE_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              advance,
   input  logic              reload,
   output logic [LANE_W-1:0] rc
);
   localparam int STEPS = 7;
   localparam logic [7:0] SEED = 8'h01;
   localparam logic [7:0] TAPS = 8'h71;

   logic [7:0]  lfsr_q, lfsr_n;
   logic [63:0] rc_full;

   always_comb begin
      lfsr_n  = lfsr_q;
      rc_full = '0;
      for (int j = 0; j < STEPS; j++) begin
         rc_full[(1 << j) - 1] = lfsr_n[0];
         lfsr_n = lfsr_n[7] ? ((lfsr_n << 1) ^ TAPS) : (lfsr_n << 1);
      end
   end

   assign rc = rc_full[LANE_W-1:0];

   always_ff @(posedge clk) begin
      if (rst || reload) lfsr_q <= SEED;
      else if (advance)  lfsr_q <= lfsr_n;
   end
endmodule

// File: rtl/ksu_steps.sv
`timescale 1ns/1ps
module ksu_steps
   import ksu_pkg::*;
#(
   parameter int LANE_W = 64
) (
   input  step_op_e                        op,
   input  logic [NUM_LANES-1:0][LANE_W-1:0] st,
   input  logic [LANE_W-1:0]               rc,
   output logic [NUM_LANES-1:0][LANE_W-1:0] nx
);
   function automatic logic [LANE_W-1:0] rotl(input logic [LANE_W-1:0] v, input int r);
      int k;
      k = r % LANE_W;
      return (k == 0) ? v : ((v << k) | (v >> (LANE_W - k)));
   endfunction

   logic [4:0][LANE_W-1:0]            par, dcol;
   logic [NUM_LANES-1:0][LANE_W-1:0] theta_o, chi_o, rhopi_o, iota_o;

   for (genvar x = 0; x < 5; x++) begin : g_col
      assign par[x]  = st[x] ^ st[x+5] ^ st[x+10] ^ st[x+15] ^ st[x+20];
      assign dcol[x] = par[(x+4)%5] ^ rotl(par[(x+1)%5], 1);
   end

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      localparam int X  = i % 5;
      localparam int RB = i - X;
      assign theta_o[i] = st[i] ^ dcol[X];
      assign chi_o[i]   = st[i] ^ (~st[RB + (X+1)%5] & st[RB + (X+2)%5]);
      if (i == 0) begin : g_rc
         assign iota_o[i] = st[i] ^ rc;
      end else begin : g_pass
         assign iota_o[i] = st[i];
      end
   end

   always_comb begin
      int px, py, qx, qy;
      rhopi_o    = st;
      px = 1;
      py = 0;
      for (int t = 0; t < 24; t++) begin
         qx = py;
         qy = (2*px + 3*py) % 5;
         rhopi_o[qx + 5*qy] = rotl(st[px + 5*py], ((t+1)*(t+2)/2) % 64);
         px = qx;
         py = qy;
      end
   end

   always_comb begin
      case (op)
         OP_THETA: nx = theta_o;
         OP_RHOPI: nx = rhopi_o;
         OP_CHI:   nx = chi_o;
         OP_IOTA:  nx = iota_o;
         default:  nx = st;
      endcase
   end
endmodule

// File: rtl/keccak_step_unit.sv
`timescale 1ns/1ps
module keccak_step_unit
   import ksu_pkg::*;
#(
   parameter int LANE_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  logic [31:0]       cmd_insn,
   output logic              cmd_ready,
   output logic              busy,
   output logic              done,
   input  logic              lane_we,
   input  logic [IDX_W-1:0]  lane_idx,
   input  logic [LANE_W-1:0] lane_wdata,
   output logic [LANE_W-1:0] lane_rdata
);
   if (LANE_W != 8 && LANE_W != 16 && LANE_W != 32 && LANE_W != 64) begin : g_bad_width
      $error("keccak_step_unit: LANE_W must be 8, 16, 32 or 64");
   end

   logic [NUM_LANES-1:0][LANE_W-1:0] lanes_q, lanes_n;
   logic                             busy_q, done_q, dec_legal, idx_ok;
   step_op_e                         dec_op, op_q;
   logic [LANE_W-1:0]                rc;

   ksu_decode u_dec (
      .insn  (cmd_insn),
      .legal (dec_legal),
      .op    (dec_op)
   );

   ksu_rc_gen #(.LANE_W(LANE_W)) u_rc (
      .clk     (clk),
      .rst     (rst),
      .advance (busy_q && op_q == OP_IOTA),
      .reload  (busy_q && op_q == OP_RCRST),
      .rc      (rc)
   );

   ksu_steps #(.LANE_W(LANE_W)) u_steps (
      .op (op_q),
      .st (lanes_q),
      .rc (rc),
      .nx (lanes_n)
   );

   assign idx_ok     = lane_idx < IDX_W'(NUM_LANES);
   assign cmd_ready  = !busy_q;
   assign busy       = busy_q;
   assign done       = done_q;
   assign lane_rdata = (!busy_q && idx_ok) ? lanes_q[lane_idx] : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         lanes_q <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         op_q    <= OP_THETA;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            lanes_q <= lanes_n;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
         end else begin
            if (cmd_valid && dec_legal) begin
               busy_q <= 1'b1;
               op_q   <= dec_op;
            end
            if (lane_we && idx_ok) lanes_q[lane_idx] <= lane_wdata;
         end
      end
   end
endmodule

// File: rtl/ksu_checker.sv
`timescale 1ns/1ps
module ksu_checker #(
   parameter int LANE_W = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              busy,
   input logic              done,
   input logic [4:0]        lane_idx,
   input logic [LANE_W-1:0] lane_rdata
);
   p_busy_single_r4: assert property (@(posedge clk) disable iff (rst) busy |=> !busy);
   p_done_follows_r4: assert property (@(posedge clk) disable iff (rst) busy |=> done);
   p_done_cause_r4: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy));
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst) done |=> !done);
   p_start_taken_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(cmd_valid && cmd_ready));
   p_read_blocked_r10: assert property (@(posedge clk) disable iff (rst)
      busy |-> lane_rdata == '0);
   p_oob_read_r2: assert property (@(posedge clk) disable iff (rst)
      (!busy && lane_idx >= 5'd25) |-> lane_rdata == '0);
endmodule

bind keccak_step_unit ksu_checker #(.LANE_W(LANE_W)) i_chk (
   .clk        (clk),
   .rst        (rst),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .busy       (busy),
   .done       (done),
   .lane_idx   (lane_idx),
   .lane_rdata (lane_rdata)
);

// File: tb/test_keccak_step_unit.sv
`timescale 1ns/1ps
module test_keccak_step_unit;
   localparam logic [31:0] I_THETA = 32'h0000000B;
   localparam logic [31:0] I_RHOPI = 32'h0000100B;
   localparam logic [31:0] I_CHI   = 32'h0000200B;
   localparam logic [31:0] I_IOTA  = 32'h0000300B;
   localparam logic [31:0] I_RCRST = 32'h0000400B;

   logic        clk = 0, rst = 1, cmd_valid = 0, lane_we = 0;
   logic [31:0] cmd_insn = '0;
   logic [4:0]  lane_idx = '0;
   logic [63:0] lane_wdata = '0;
   logic        cmd_ready, busy, done;
   logic [63:0] lane_rdata;

   int total = 0, bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   keccak_step_unit #(.LANE_W(64)) i_keccak_step_unit (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_insn(cmd_insn),
      .cmd_ready(cmd_ready), .busy(busy), .done(done), .lane_we(lane_we),
      .lane_idx(lane_idx), .lane_wdata(lane_wdata), .lane_rdata(lane_rdata)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference state
   logic [63:0] m [25];
   logic [7:0]  gen;

   function automatic logic [63:0] rl(input logic [63:0] v, input int r);
      int k = r % 64;
      return (k == 0) ? v : ((v << k) | (v >> (64 - k)));
   endfunction

   task automatic m_theta();
      logic [63:0] c [5];
      for (int x = 0; x < 5; x++) c[x] = m[x] ^ m[x+5] ^ m[x+10] ^ m[x+15] ^ m[x+20];
      for (int x = 0; x < 5; x++)
         for (int y = 0; y < 5; y++) m[x+5*y] ^= c[(x+4)%5] ^ rl(c[(x+1)%5], 1);
   endtask

   task automatic m_rhopi();
      logic [63:0] carry, keep;
      int cx = 1, cy = 0, ny;
      carry = m[1];
      for (int t = 0; t < 24; t++) begin
         ny = (2*cx + 3*cy) % 5;
         cx = cy;
         cy = ny;
         keep = m[cx+5*cy];
         m[cx+5*cy] = rl(carry, (t+1)*(t+2)/2);
         carry = keep;
      end
   endtask

   task automatic m_chi();
      logic [63:0] row [5];
      for (int y = 0; y < 5; y++) begin
         for (int x = 0; x < 5; x++) row[x] = m[x+5*y];
         for (int x = 0; x < 5; x++) m[x+5*y] = row[x] ^ (~row[(x+1)%5] & row[(x+2)%5]);
      end
   endtask

   task automatic m_iota();
      for (int j = 0; j < 7; j++) begin
         if (gen[0]) m[0] ^= 64'd1 << ((1 << j) - 1);
         gen = gen[7] ? ((gen << 1) ^ 8'h71) : (gen << 1);
      end
   endtask

   // scoreboard: driver pushes expected lanes, monitor compares
   logic [63:0] exp_q [$];
   string       tag_q [$];
   bit          mon_en = 0;

   always @(negedge clk) begin
      if (mon_en && exp_q.size() > 0) begin
         logic [63:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(lane_rdata === e, t, lane_rdata, e);
      end
   end

   task automatic compare_all(input string tag);
      for (int i = 0; i < 25; i++) begin
         @(posedge clk); #1;
         lane_idx = 5'(i);
         exp_q.push_back(m[i]);
         tag_q.push_back(tag);
         mon_en = 1;
      end
      @(posedge clk); #1;
      mon_en = 0;
   endtask

   task automatic wr(input int idx, input logic [63:0] d);
      @(posedge clk); #1;
      lane_we = 1; lane_idx = 5'(idx); lane_wdata = d;
      @(posedge clk); #1;
      lane_we = 0;
   endtask

   task automatic issue(input logic [31:0] insn, input bit legal, input string tag);
      @(posedge clk); #1;
      cmd_valid = 1; cmd_insn = insn;
      do @(negedge clk); while (!cmd_ready);
      @(posedge clk); #1;
      cmd_valid = 0;
      @(negedge clk);
      chk(busy == legal, {tag, " busy"}, 64'(busy), 64'(legal));
      chk(cmd_ready == !legal, {tag, " ready"}, 64'(cmd_ready), 64'(!legal));
      @(negedge clk);
      chk(done == legal && !busy, {tag, " done"}, 64'(done), 64'(legal));
   endtask

   task automatic round_cmds(input string tag);
      issue(I_THETA, 1, tag); m_theta();
      issue(I_RHOPI, 1, tag); m_rhopi();
      issue(I_CHI,   1, tag); m_chi();
      issue(I_IOTA,  1, tag); m_iota();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 25; i++) m[i] = '0;
      gen = 8'h01;
      repeat (3) @(posedge clk);
      #1 rst = 0;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done && cmd_ready, "R1 flags", {61'd0, busy, done, cmd_ready}, 64'd1);
      compare_all("R1");

      // R2 lane writes and reads
      for (int i = 0; i < 25; i++) begin
         m[i] = (64'h0123456789ABCDEF * 64'(i + 3)) ^ {32'(i), 32'hA5A5_0000 | 32'(i)};
         wr(i, m[i]);
      end
      compare_all("R2");
      wr(25, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(31, 64'h1234_5678_9ABC_DEF0);
      @(posedge clk); #1 lane_idx = 5'd25;
      @(negedge clk) chk(lane_rdata == 0, "R2 oob25", lane_rdata, 0);
      @(posedge clk); #1 lane_idx = 5'd31;
      @(negedge clk) chk(lane_rdata == 0, "R2 oob31", lane_rdata, 0);
      compare_all("R2");

      // R5 theta, R6 rho-pi, R7 chi
      issue(I_THETA, 1, "R5"); m_theta(); compare_all("R5");
      issue(I_RHOPI, 1, "R6"); m_rhopi(); compare_all("R6");
      issue(I_CHI,   1, "R7"); m_chi();   compare_all("R7");

      // R8 iota twice, R9 reload then iota
      issue(I_IOTA, 1, "R8"); m_iota(); compare_all("R8");
      issue(I_IOTA, 1, "R8"); m_iota(); compare_all("R8");
      issue(I_RCRST, 1, "R9"); gen = 8'h01; compare_all("R9");
      issue(I_IOTA, 1, "R9"); m_iota(); compare_all("R9");

      // R3 illegal words
      issue(32'h0000500B, 0, "R3");
      issue(32'h0000008B, 0, "R3");
      issue(32'h0200000B, 0, "R3");
      issue(32'h0000000F, 0, "R3");
      issue(32'h0010000B, 0, "R3");
      compare_all("R3");

      // R10 lane port blocked while busy
      @(posedge clk); #1;
      cmd_valid = 1; cmd_insn = I_CHI;
      @(posedge clk); #1;
      cmd_valid = 0;
      lane_we = 1; lane_idx = 5'd2; lane_wdata = 64'hDEAD_BEEF_CAFE_F00D;
      @(negedge clk);
      chk(busy, "R10 busy", 64'(busy), 1);
      chk(lane_rdata == 0, "R10 read", lane_rdata, 0);
      @(posedge clk); #1 lane_we = 0;
      m_chi();
      compare_all("R10");

      // R4 command held while busy
      @(posedge clk); #1;
      cmd_valid = 1; cmd_insn = I_THETA;
      @(posedge clk); #1;
      cmd_insn = I_IOTA;
      @(negedge clk);
      chk(busy && !cmd_ready, "R4 held busy", {62'd0, busy, cmd_ready}, 64'd2);
      @(posedge clk); #1;
      @(negedge clk);
      chk(done && !busy && cmd_ready, "R4 held done", {61'd0, done, busy, cmd_ready}, 64'd5);
      @(posedge clk); #1 cmd_valid = 0;
      @(negedge clk) chk(busy, "R4 second busy", 64'(busy), 1);
      @(negedge clk) chk(done, "R4 second done", 64'(done), 1);
      m_theta(); m_iota();
      compare_all("R4");

      // R11 full permutation on zero state
      for (int i = 0; i < 25; i++) begin
         m[i] = '0;
         wr(i, 64'd0);
      end
      issue(I_RCRST, 1, "R11"); gen = 8'h01;
      for (int r = 0; r < 24; r++) round_cmds("R11");
      chk(m[0] == 64'hF1258F7940E1DDE7, "R11 model lane0", m[0], 64'hF1258F7940E1DDE7);
      @(posedge clk); #1 lane_idx = 5'd0;
      @(negedge clk) chk(lane_rdata == 64'hF1258F7940E1DDE7, "R11 lane0", lane_rdata, 64'hF1258F7940E1DDE7);
      @(posedge clk); #1 lane_idx = 5'd1;
      @(negedge clk) chk(lane_rdata == 64'h84D5CCF933C0478A, "R11 lane1", lane_rdata, 64'h84D5CCF933C0478A);
      compare_all("R11");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule